// File: doc/BRIEF.md
# Ring-Resolved Translation Buffer with Autorefill

This block translates virtual addresses to physical addresses through a small set-associative translation buffer with four ways of four sets and fixed 4 KiB pages. Each request carries a virtual address, an access kind (read, write or instruction fetch) and the privilege ring of the requester. The block answers with a physical address and the read, write and execute rights of the page, or with a fault cause code.

Entries carry an address-space identifier and not a ring number. The ring of an entry is found at lookup time by comparing its identifier with the four bytes of a ring-identifier register. An entry whose identifier appears in no byte of that register does not take part in the lookup. When no way hits, the block computes the address of the page-table entry from a page-table base input. It fetches that word over a valid/ready memory port and writes the word into a victim way that rotates over the four ways. It then answers from the fetched word.

Top module: `asidRingTlb`

## Requirements
- R1: After reset, reqReady is 1 and rspValid and memReqValid are 0. The ring-identifier register holds 0x04030201 and every entry identifier is zero, so the first request always goes to memory.
- R2: A way hits only if its stored page number equals the address bits 31:12, its identifier is non-zero and its identifier equals a byte of the ring-identifier register. The entry's ring is the index of the lowest matching byte, where bits 7:0 are ring 0 and bits 31:24 are ring 3. ringIdWe loads ringIdData into that register.
- R3: When two or more ways hit, the response faults with no memory request. The cause is 25 for reads, writes and access kind 3, and 17 for fetches.
- R4: When no way hits, a memory read is issued at (ptBase | (vaddr >> 10)) with bits 1:0 cleared. An error on the returned word gives a miss fault: cause 24 for data and 16 for fetch.
- R5: A fetched word w is installed at set vaddr[13:12] with page base w[31:12], attribute w[3:0] and the identifier held in the ring-identifier byte selected by w[5:4]. The response uses ring w[5:4], and a later access to the same page hits without a memory request.
- R6: The victim way is a 2-bit counter that starts at 0 and is incremented before each install. Five installs into one set therefore evict the page installed first.
- R7: If the entry ring is numerically below reqRing, the response faults with cause 26 for data and 18 for fetch. This check comes after the multi-hit and miss checks and before the rights check.
- R8: Attribute a grants read when a < 12, adding execute when a[0] is set and write when a[1] is set. a = 13 grants read and write only. Every other value grants nothing.
- R9: Access kind 0 is read, 1 is write, 2 is fetch and 3 is never granted. A denied access faults with cause 29 for a write, 20 for a fetch and 28 otherwise.
- R10: A response without a fault has cause 0, the physical address {page base, vaddr[11:0]} and the decoded rights on rspRead, rspWrite and rspExec.
- R11: rspValid is a one-cycle pulse. memReqValid stays high with a stable address until memReqReady is high. reqReady is low while a request is being handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | Block idle and accepting a request |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 none |
| reqRing | input | 2 | Current privilege ring |
| rspValid | output | 1 | Response strobe |
| rspFault | output | 1 | Response is a fault |
| rspCause | output | 6 | Fault cause, 0 when no fault |
| rspPaddr | output | 32 | Physical address |
| rspRead | output | 1 | Page grants read |
| rspWrite | output | 1 | Page grants write |
| rspExec | output | 1 | Page grants execute |
| ringIdWe | input | 1 | Write strobe for the ring-identifier register |
| ringIdData | input | 32 | New ring-identifier value |
| ptBase | input | 32 | Page-table base address |
| memReqValid | output | 1 | Page-table read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Page-table entry address |
| memRspValid | input | 1 | Page-table word returned |
| memRspData | input | 32 | Page-table word |
| memRspErr | input | 1 | Page-table read failed |

## Verification
Refill never installs a page that already hits, so a multi-hit cannot be reached directly from the ports. The stimulus builds one. It installs a page under identifier 1. It then rewrites the ring-identifier register so that identifier 1 matches no byte, which makes the next access miss and install a second copy under identifier 5. A last register write maps both identifiers to rings at once. Victim rotation is covered by filling one set with four new pages and then watching which old page must be fetched again.

// File: rtl/asidTlbPkg.sv
package asidTlbPkg;

  localparam int ATTR_W = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } accKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MEMREQ,
    ST_MEMWAIT,
    ST_RESP
  } tlbState_t;

  localparam logic [5:0] CAUSE_NONE       = 6'd0;
  localparam logic [5:0] CAUSE_I_MISS     = 6'd16;
  localparam logic [5:0] CAUSE_I_MULTI    = 6'd17;
  localparam logic [5:0] CAUSE_I_PRIV     = 6'd18;
  localparam logic [5:0] CAUSE_I_PROHIB   = 6'd20;
  localparam logic [5:0] CAUSE_D_MISS     = 6'd24;
  localparam logic [5:0] CAUSE_D_MULTI    = 6'd25;
  localparam logic [5:0] CAUSE_D_PRIV     = 6'd26;
  localparam logic [5:0] CAUSE_LD_PROHIB  = 6'd28;
  localparam logic [5:0] CAUSE_ST_PROHIB  = 6'd29;

  typedef struct packed {
    logic captureReq;
    logic latchLook;
    logic installRefill;
    logic refillFail;
  } tlbStrobe_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  function automatic perm_t decodeAttr(input logic [ATTR_W-1:0] attr);
    perm_t p;
    p = '0;
    if (attr < 4'd12) begin
      p.rd = 1'b1;
      p.ex = attr[0];
      p.wr = attr[1];
    end else if (attr == 4'd13) begin
      p.rd = 1'b1;
      p.wr = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import asidTlbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lookMiss,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       memRspErr,
  output tlbStrobe_t strobe,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       rspValid
);

  tlbState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          nextState = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lookMiss) begin
          nextState = ST_MEMREQ;
        end else begin
          strobe.latchLook = 1'b1;
          nextState = ST_RESP;
        end
      end
      ST_MEMREQ: begin
        if (memReqReady) nextState = ST_MEMWAIT;
      end
      ST_MEMWAIT: begin
        if (memRspValid) begin
          if (memRspErr) strobe.refillFail    = 1'b1;
          else           strobe.installRefill = 1'b1;
          nextState = ST_RESP;
        end
      end
      ST_RESP: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_MEMREQ);
  assign rspValid    = (state == ST_RESP);

endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import asidTlbPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int ASID_W     = 8,
  parameter int RINGS      = 4,
  parameter int PTE_RING_LSB = 4,
  parameter logic [RINGS*ASID_W-1:0] RINGID_RESET = 32'h04030201
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tlbStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       reqVaddr,
  input  logic [1:0]              reqAccess,
  input  logic [$clog2(RINGS)-1:0] reqRing,
  input  logic [ADDR_W-1:0]       ptBase,
  input  logic                    ringIdWe,
  input  logic [RINGS*ASID_W-1:0] ringIdData,
  input  logic [ADDR_W-1:0]       memRspData,
  output logic                    lookMiss,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic                    rspFault,
  output logic [5:0]              rspCause,
  output logic [ADDR_W-1:0]       rspPaddr,
  output logic                    rspRead,
  output logic                    rspWrite,
  output logic                    rspExec
);

  localparam int VPN_W     = ADDR_W - PAGE_BITS;
  localparam int IDX_W     = $clog2(SETS);
  localparam int WAY_W     = $clog2(WAYS);
  localparam int RING_W    = $clog2(RINGS);
  localparam int PTE_SHIFT = PAGE_BITS - 2;

  // captured request
  logic [ADDR_W-1:0] curVa;
  logic [1:0]        curAcc;
  logic [RING_W-1:0] curRing;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curVa   <= '0;
      curAcc  <= '0;
      curRing <= '0;
    end else if (strobe.captureReq) begin
      curVa   <= reqVaddr;
      curAcc  <= reqAccess;
      curRing <= reqRing;
    end
  end

  // ring-identifier register
  logic [RINGS*ASID_W-1:0] ringIdReg;

  always_ff @(posedge clk) begin
    if (!rstN)         ringIdReg <= RINGID_RESET;
    else if (ringIdWe) ringIdReg <= ringIdData;
  end

  // entry storage
  logic [ASID_W-1:0] asidMem [WAYS][SETS];
  logic [VPN_W-1:0]  vpnMem  [WAYS][SETS];
  logic [VPN_W-1:0]  ppnMem  [WAYS][SETS];
  logic [ATTR_W-1:0] attrMem [WAYS][SETS];
  logic [WAY_W-1:0]  victimCnt;

  logic [IDX_W-1:0]  setIdx;
  logic [VPN_W-1:0]  curVpn;
  logic [RING_W-1:0] pteRing;
  logic [WAY_W-1:0]  victimWay;

  assign setIdx    = curVa[PAGE_BITS +: IDX_W];
  assign curVpn    = curVa[ADDR_W-1:PAGE_BITS];
  assign pteRing   = memRspData[PTE_RING_LSB +: RING_W];
  assign victimWay = victimCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimCnt <= '0;
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          asidMem[w][s] <= '0;
          vpnMem[w][s]  <= '0;
          ppnMem[w][s]  <= '0;
          attrMem[w][s] <= '0;
        end
      end
    end else if (strobe.installRefill) begin
      victimCnt                  <= victimWay;
      asidMem[victimWay][setIdx] <= ringIdReg[pteRing*ASID_W +: ASID_W];
      vpnMem[victimWay][setIdx]  <= curVpn;
      ppnMem[victimWay][setIdx]  <= memRspData[ADDR_W-1:PAGE_BITS];
      attrMem[victimWay][setIdx] <= memRspData[ATTR_W-1:0];
    end
  end

  // per-way ring resolution and hit detection
  logic [WAYS-1:0]   hitVec;
  logic [RING_W-1:0] wayRing [WAYS];

  for (genvar gw = 0; gw < WAYS; gw++) begin : gWay
    logic              ringFound;
    logic [RING_W-1:0] ringIdx;
    logic [ASID_W-1:0] wayAsid;

    assign wayAsid = asidMem[gw][setIdx];

    always_comb begin
      ringFound = 1'b0;
      ringIdx   = '0;
      for (int r = RINGS - 1; r >= 0; r--) begin
        if (ringIdReg[r*ASID_W +: ASID_W] == wayAsid) begin
          ringFound = 1'b1;
          ringIdx   = RING_W'(r);
        end
      end
    end

    assign wayRing[gw] = ringIdx;
    assign hitVec[gw]  = (wayAsid != '0) && ringFound &&
                         (vpnMem[gw][setIdx] == curVpn);
  end

  logic              lookMulti;
  logic [RING_W-1:0] hitRing;
  logic [VPN_W-1:0]  hitPpn;
  logic [ATTR_W-1:0] hitAttr;

  assign lookMiss  = (hitVec == '0);
  assign lookMulti = ($countones(hitVec) > 1);

  always_comb begin
    hitRing = '0;
    hitPpn  = '0;
    hitAttr = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        hitRing = wayRing[w];
        hitPpn  = ppnMem[w][setIdx];
        hitAttr = attrMem[w][setIdx];
      end
    end
  end

  // page-table entry address
  assign memReqAddr = (ptBase | (curVa >> PTE_SHIFT)) & ~ADDR_W'(3);

  // response evaluation
  logic              useRefill;
  logic [RING_W-1:0] selRing;
  logic [VPN_W-1:0]  selPpn;
  logic [ATTR_W-1:0] selAttr;
  perm_t             selPerm;
  logic              granted;
  logic              isFetch;
  logic              nFault;
  logic [5:0]        nCause;

  assign useRefill = strobe.installRefill;
  assign isFetch   = (curAcc == ACC_FETCH);

  always_comb begin
    if (useRefill) begin
      selRing = pteRing;
      selPpn  = memRspData[ADDR_W-1:PAGE_BITS];
      selAttr = memRspData[ATTR_W-1:0];
    end else begin
      selRing = hitRing;
      selPpn  = hitPpn;
      selAttr = hitAttr;
    end
    selPerm = decodeAttr(selAttr);
    case (curAcc)
      ACC_READ:  granted = selPerm.rd;
      ACC_WRITE: granted = selPerm.wr;
      ACC_FETCH: granted = selPerm.ex;
      default:   granted = 1'b0;
    endcase
    nFault = 1'b1;
    if (strobe.refillFail) begin
      nCause = isFetch ? CAUSE_I_MISS : CAUSE_D_MISS;
    end else if (!useRefill && lookMulti) begin
      nCause = isFetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    end else if (selRing < curRing) begin
      nCause = isFetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    end else if (!granted) begin
      nCause = isFetch ? CAUSE_I_PROHIB :
               (curAcc == ACC_WRITE) ? CAUSE_ST_PROHIB : CAUSE_LD_PROHIB;
    end else begin
      nFault = 1'b0;
      nCause = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspFault <= 1'b0;
      rspCause <= CAUSE_NONE;
      rspPaddr <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
    end else if (strobe.latchLook || strobe.installRefill || strobe.refillFail) begin
      rspFault <= nFault;
      rspCause <= nCause;
      rspPaddr <= {selPpn, curVa[PAGE_BITS-1:0]};
      rspRead  <= selPerm.rd;
      rspWrite <= selPerm.wr;
      rspExec  <= selPerm.ex;
    end
  end

endmodule

// File: rtl/asidRingTlb.sv
module asidRingTlb
  import asidTlbPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int ASID_W    = 8,
  parameter int RINGS     = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqVaddr,
  input  logic [1:0]              reqAccess,
  input  logic [$clog2(RINGS)-1:0] reqRing,
  output logic                    rspValid,
  output logic                    rspFault,
  output logic [5:0]              rspCause,
  output logic [ADDR_W-1:0]       rspPaddr,
  output logic                    rspRead,
  output logic                    rspWrite,
  output logic                    rspExec,
  input  logic                    ringIdWe,
  input  logic [RINGS*ASID_W-1:0] ringIdData,
  input  logic [ADDR_W-1:0]       ptBase,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRspValid,
  input  logic [ADDR_W-1:0]       memRspData,
  input  logic                    memRspErr
);

  tlbStrobe_t strobe;
  logic       lookMiss;

  tlbCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .lookMiss    (lookMiss),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid)
  );

  tlbDatapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .SETS      (SETS),
    .WAYS      (WAYS),
    .ASID_W    (ASID_W),
    .RINGS     (RINGS)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .reqRing    (reqRing),
    .ptBase     (ptBase),
    .ringIdWe   (ringIdWe),
    .ringIdData (ringIdData),
    .memRspData (memRspData),
    .lookMiss   (lookMiss),
    .memReqAddr (memReqAddr),
    .rspFault   (rspFault),
    .rspCause   (rspCause),
    .rspPaddr   (rspPaddr),
    .rspRead    (rspRead),
    .rspWrite   (rspWrite),
    .rspExec    (rspExec)
  );

endmodule

// File: rtl/tlbChecker.sv
module tlbChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspFault,
  input logic [5:0]        rspCause,
  input logic              rspRead,
  input logic              rspExec,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr
);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rspValid) |-> !reqReady);

  assert_pte_align_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00));

  assert_ok_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspCause == 6'd0));

  assert_fault_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspCause inside {6'd16, 6'd17, 6'd18, 6'd20,
                                                 6'd24, 6'd25, 6'd26, 6'd28, 6'd29}));

  assert_exec_reads_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault && rspExec) |-> rspRead);

endmodule

bind asidRingTlb tlbChecker #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspFault    (rspFault),
  .rspCause    (rspCause),
  .rspRead     (rspRead),
  .rspExec     (rspExec),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr)
);

// File: tb/test_asidRingTlb.sv
module test_asidRingTlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic [1:0]  reqRing = '0;
  logic        rspValid, rspFault, rspRead, rspWrite, rspExec;
  logic [5:0]  rspCause;
  logic [31:0] rspPaddr;
  logic        ringIdWe = 1'b0;
  logic [31:0] ringIdData = '0;
  logic [31:0] ptBase = 32'h8000_0000;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        memRspErr = 1'b0;

  always #10 clk = ~clk;

  asidRingTlb i_asidRingTlb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqRing(reqRing),
    .rspValid(rspValid), .rspFault(rspFault), .rspCause(rspCause),
    .rspPaddr(rspPaddr), .rspRead(rspRead), .rspWrite(rspWrite), .rspExec(rspExec),
    .ringIdWe(ringIdWe), .ringIdData(ringIdData), .ptBase(ptBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr)
  );

  int errors = 0;
  int checks = 0;
  int reqSeen = 0;
  int stall = 0;
  logic        pend = 1'b0;
  logic [31:0] ptePlan = '0;
  logic        errPlan = 1'b0;
  logic [31:0] lastReqAddr = '0;

  logic        oGot, oFault, oRefill;
  logic [5:0]  oCause;
  logic [31:0] oPaddr;
  logic [2:0]  oPerm;

  // memory model for the page-table port
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        memRspValid = 1'b1;
        memRspData  = ptePlan;
        memRspErr   = errPlan;
        pend        = 1'b0;
      end
      if (memReqValid) begin
        if (stall > 0) begin
          memReqReady = 1'b0;
          stall--;
        end else begin
          memReqReady = 1'b1;
          lastReqAddr = memReqAddr;
          reqSeen++;
          pend = 1'b1;
        end
      end else begin
        memReqReady = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setRingId(input logic [31:0] v);
    @(negedge clk);
    ringIdWe = 1'b1;
    ringIdData = v;
    @(negedge clk);
    ringIdWe = 1'b0;
  endtask

  task automatic doAccess(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] ring,
                          input logic [31:0] pte, input logic err);
    int startSeen;
    ptePlan = pte;
    errPlan = err;
    startSeen = reqSeen;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = va;
    reqAccess = acc;
    reqRing = ring;
    @(negedge clk);
    reqValid = 1'b0;
    oGot = 1'b0;
    for (int k = 0; k < 60 && !oGot; k++) begin
      if (rspValid) begin
        oGot   = 1'b1;
        oFault = rspFault;
        oCause = rspCause;
        oPaddr = rspPaddr;
        oPerm  = {rspRead, rspWrite, rspExec};
      end else begin
        @(negedge clk);
      end
    end
    oRefill = (reqSeen != startSeen);
    check(oGot, "R11 response arrives", {31'd0, oGot}, 32'd1);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [1:0]  ring;
    logic [31:0] pte;
    logic        refill;
    logic [31:0] memAddr;
    logic        fault;
    logic [5:0]  cause;
    logic [31:0] paddr;
    logic [2:0]  perm;   // {read, write, exec}
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1234, 2'd0, 2'd0, 32'h1234_5003, 1'b1, 32'h8000_0004, 1'b0, 6'd0,  32'h1234_5234, 3'b111},
    '{32'h0000_1234, 2'd1, 2'd0, 32'h0,        1'b0, 32'h0,        1'b0, 6'd0,  32'h1234_5234, 3'b111},
    '{32'h0000_1234, 2'd2, 2'd1, 32'h0,        1'b0, 32'h0,        1'b1, 6'd18, 32'h0,        3'b000},
    '{32'h0000_2010, 2'd0, 2'd2, 32'hABCD_E03C, 1'b1, 32'h8000_0008, 1'b1, 6'd28, 32'h0,       3'b000},
    '{32'h0000_2010, 2'd2, 2'd3, 32'h0,        1'b0, 32'h0,        1'b1, 6'd20, 32'h0,        3'b000},
    '{32'h0000_3FFC, 2'd1, 2'd0, 32'h0077_702D, 1'b1, 32'h8000_000C, 1'b0, 6'd0, 32'h0077_7FFC, 3'b110},
    '{32'h0000_3FFC, 2'd2, 2'd0, 32'h0,        1'b0, 32'h0,        1'b1, 6'd20, 32'h0,        3'b000},
    '{32'h0000_4000, 2'd1, 2'd0, 32'h0004_2001, 1'b1, 32'h8000_0010, 1'b1, 6'd29, 32'h0,       3'b000},
    '{32'h0000_4000, 2'd0, 2'd0, 32'h0,        1'b0, 32'h0,        1'b0, 6'd0,  32'h0004_2000, 3'b101},
    '{32'h0000_4000, 2'd3, 2'd0, 32'h0,        1'b0, 32'h0,        1'b1, 6'd28, 32'h0,        3'b000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady after reset", {31'd0, reqReady}, 32'd1);
    check(rspValid == 1'b0, "R1 rspValid after reset", {31'd0, rspValid}, 32'd0);
    check(memReqValid == 1'b0, "R1 memReqValid after reset", {31'd0, memReqValid}, 32'd0);

    // vector table: R2 R4 R5 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      doAccess(VECS[i].va, VECS[i].acc, VECS[i].ring, VECS[i].pte, 1'b0);
      check(oRefill == VECS[i].refill, $sformatf("R5 vec%0d refill", i), {31'd0, oRefill}, {31'd0, VECS[i].refill});
      if (VECS[i].refill)
        check(lastReqAddr == VECS[i].memAddr, $sformatf("R4 vec%0d pte address", i), lastReqAddr, VECS[i].memAddr);
      check(oFault == VECS[i].fault, $sformatf("R9 vec%0d fault", i), {31'd0, oFault}, {31'd0, VECS[i].fault});
      check(oCause == VECS[i].cause, $sformatf("R7 vec%0d cause", i), {26'd0, oCause}, {26'd0, VECS[i].cause});
      if (!VECS[i].fault) begin
        check(oPaddr == VECS[i].paddr, $sformatf("R10 vec%0d paddr", i), oPaddr, VECS[i].paddr);
        check(oPerm == VECS[i].perm, $sformatf("R8 vec%0d perm", i), {29'd0, oPerm}, {29'd0, VECS[i].perm});
      end
    end

    // R6 victim rotation: four new pages in set 1 evict page 0x1000
    for (int p = 1; p <= 4; p++) begin
      doAccess(32'h0000_1000 + (p << 16), 2'd0, 2'd0, 32'h0000_0003 | (p << 12), 1'b0);
      check(oRefill, "R6 new page refills", {31'd0, oRefill}, 32'd1);
    end
    doAccess(32'h0000_1234, 2'd0, 2'd0, 32'h1234_5003, 1'b0);
    check(oRefill, "R6 oldest page evicted", {31'd0, oRefill}, 32'd1);
    doAccess(32'h0002_1000, 2'd0, 2'd0, 32'h0, 1'b0);
    check(!oRefill, "R6 second page kept", {31'd0, oRefill}, 32'd0);
    check(oPaddr == 32'h0000_2000, "R6 second page paddr", oPaddr, 32'h0000_2000);
    doAccess(32'h0001_1000, 2'd0, 2'd0, 32'h0000_1003, 1'b0);
    check(oRefill, "R6 first new page evicted next", {31'd0, oRefill}, 32'd1);

    // R3 multi-hit built through identifier remapping
    doAccess(32'h0000_7000, 2'd0, 2'd0, 32'h0007_7003, 1'b0);
    check(oRefill, "R3 setup first copy", {31'd0, oRefill}, 32'd1);
    setRingId(32'h0403_0205);
    doAccess(32'h0000_7000, 2'd0, 2'd0, 32'h0007_7003, 1'b0);
    check(oRefill, "R2 unmatched identifier misses", {31'd0, oRefill}, 32'd1);
    setRingId(32'h0403_0105);
    doAccess(32'h0000_7000, 2'd0, 2'd0, 32'h0, 1'b0);
    check(!oRefill, "R3 no refill on multi-hit", {31'd0, oRefill}, 32'd0);
    check(oFault && oCause == 6'd25, "R3 data multi-hit cause", {26'd0, oCause}, 32'd25);
    doAccess(32'h0000_7000, 2'd2, 2'd0, 32'h0, 1'b0);
    check(oFault && oCause == 6'd17, "R3 fetch multi-hit cause", {26'd0, oCause}, 32'd17);
    setRingId(32'h0403_0201);
    doAccess(32'h0000_7000, 2'd1, 2'd0, 32'h0, 1'b0);
    check(!oFault && !oRefill, "R2 single hit after remap", {26'd0, oCause}, 32'd0);

    // R2 zero identifier never hits
    setRingId(32'h0403_0200);
    doAccess(32'h0000_6000, 2'd0, 2'd0, 32'h0006_6003, 1'b0);
    check(oRefill && !oFault, "R5 install with zero identifier", {31'd0, oRefill}, 32'd1);
    doAccess(32'h0000_6000, 2'd0, 2'd0, 32'h0006_6003, 1'b0);
    check(oRefill, "R2 zero identifier refills again", {31'd0, oRefill}, 32'd1);
    setRingId(32'h0403_0201);

    // R4 refill error gives miss causes
    doAccess(32'h0000_9000, 2'd0, 2'd0, 32'h0, 1'b1);
    check(oFault && oCause == 6'd24, "R4 data miss cause", {26'd0, oCause}, 32'd24);
    doAccess(32'h0000_9000, 2'd2, 2'd0, 32'h0, 1'b1);
    check(oFault && oCause == 6'd16, "R4 fetch miss cause", {26'd0, oCause}, 32'd16);

    // R11 stalled memory request
    stall = 3;
    doAccess(32'h0000_A000, 2'd0, 2'd1, 32'h000A_A013, 1'b0);
    check(lastReqAddr == 32'h8000_0028, "R11 stalled request address", lastReqAddr, 32'h8000_0028);
    check(!oFault && oPaddr == 32'h000A_A000, "R11 stalled response", oPaddr, 32'h000A_A000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule